// File: doc/BRIEF.md
# Four-Phase ROM Read Handshake

This block carries one word read from a small read-only memory across a boundary between two unrelated clocks. A requester, clocked by `clk_req`, accepts a start pulse with an address. It puts the address on an internal bus, raises a read-request line one cycle later, and waits. A responder, clocked by `clk_mem`, idles until it sees the request. It holds the request through a programmable number of access cycles, then places the memory word on a data bus and raises a completion line.

The two lines follow a return-to-zero four-phase sequence. The request rises, then completion rises, then the request falls, then completion falls. Each side passes the other side's handshake line through a two-flop synchronizer before acting on it. The requester captures the word when it sees completion high, and only then drops its request. It reports the end of the transfer with a one-cycle pulse once it sees completion low again.

The memory contents are computed. The word at address `a` is `((a*37 + 11) mod 2^DW) XOR (a >> 1)`. With the default `AW = DW = 8`, the memory holds 256 words.

Top module: `rom_rd_hs_top`

## Requirements
- R1: While either reset is held, and right after it, `busy_o`, `done_o`, `rd_o` and `cmp_o` are 0 and `data_o` is 0.
- R2: A `start_i` sampled high at a `clk_req` edge while idle raises `busy_o` at that edge. It raises `rd_o` exactly one `clk_req` edge later, so the address is on the bus before the request.
- R3: When the transfer ends, `data_o` equals the memory word for the accepted address, `((a*37 + 11) mod 2^DW) XOR (a >> 1)`.
- R4: The handshake order is always: `rd_o` rises while `cmp_o` is low; `cmp_o` rises only while `rd_o` is high; `rd_o` falls only while `cmp_o` is high; `cmp_o` falls only while `rd_o` is low.
- R5: The internal address bus stays stable while `rd_o` is high. The internal data bus stays stable while `cmp_o` is high.
- R6: `done_o` is a single-cycle pulse. It is issued once per transfer, after `cmp_o` has returned low, and at that point `busy_o` is already 0.
- R7: A `start_i` pulse while `busy_o` is high is ignored. The transfer in flight returns the word for its own address, and no second transfer starts.
- R8: With `LATENCY` access cycles, `cmp_o` rises after the rise of `rd_o`. The gap is between `LATENCY+2` and `LATENCY+5` `clk_mem` cycles, which covers two synchronizer stages, the idle-to-access step and `LATENCY+1` access cycles.
- R9: `data_o` keeps the last captured word between transfers. The responder starts a new access only after `cmp_o` has returned low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_req | input | 1 | Requester clock |
| rst_req_n | input | 1 | Requester asynchronous reset, active low |
| start_i | input | 1 | Start a read (requester domain) |
| addr_i | input | AW | Address sampled with `start_i` |
| busy_o | output | 1 | A transfer is in flight |
| done_o | output | 1 | One-cycle end-of-transfer pulse |
| data_o | output | DW | Word returned by the last transfer |
| clk_mem | input | 1 | Responder clock |
| rst_mem_n | input | 1 | Responder asynchronous reset, active low |
| rd_o | output | 1 | Read-request line, observable |
| cmp_o | output | 1 | Completion line, observable |

## Verification
A corrupted state in either controller breaks the four-phase order on `rd_o` and `cmp_o`. The break is visible within a few cycles of the faulty transition, or the transfer hangs and `done_o` never arrives. A wrong capture or address shows up as a mismatch on `data_o` at the `done_o` pulse of that same transfer. Random addresses, including the lowest and the highest, together with starts issued while busy, cover these paths.

// File: rtl/rom_rd_hs_pkg.sv
package rom_rd_hs_pkg;

    typedef enum logic [1:0] {
        RQ_IDLE  = 2'd0,
        RQ_SETUP = 2'd1,
        RQ_WHI   = 2'd2,
        RQ_WLO   = 2'd3
    } rq_state_e;

    typedef enum logic [1:0] {
        RS_IDLE   = 2'd0,
        RS_ACCESS = 2'd1,
        RS_HOLD   = 2'd2
    } rs_state_e;

endpackage

// File: rtl/rom_rd_hs_sync2.sv
module rom_rd_hs_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);
    logic meta_q;
    logic stab_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            stab_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            stab_q <= meta_q;
        end
    end

    assign sync_o = stab_q;
endmodule

// File: rtl/rom_rd_hs_requester.sv
module rom_rd_hs_requester
    import rom_rd_hs_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic          cmp_i,
    input  logic [DW-1:0] mem_data_i,
    output logic          rd_o,
    output logic [AW-1:0] addr_o,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] data_o
);
    typedef struct packed {
        rq_state_e     state;
        logic [AW-1:0] addr;
        logic          rd;
        logic [DW-1:0] data;
        logic          done;
    } rq_regs_t;

    rq_regs_t rq_d, rq_q;
    logic     cmp_s;

    rom_rd_hs_sync2 cmp_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (cmp_i),
        .sync_o  (cmp_s)
    );

    always_comb begin
        rq_d      = rq_q;
        rq_d.done = 1'b0;
        case (rq_q.state)
            RQ_IDLE: begin
                if (start_i) begin
                    rq_d.addr  = addr_i;
                    rq_d.state = RQ_SETUP;
                end
            end
            RQ_SETUP: begin
                rq_d.rd    = 1'b1;
                rq_d.state = RQ_WHI;
            end
            RQ_WHI: begin
                if (cmp_s) begin
                    rq_d.data  = mem_data_i;
                    rq_d.rd    = 1'b0;
                    rq_d.state = RQ_WLO;
                end
            end
            RQ_WLO: begin
                if (!cmp_s) begin
                    rq_d.done  = 1'b1;
                    rq_d.state = RQ_IDLE;
                end
            end
            default: rq_d.state = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rq_q.state <= RQ_IDLE;
            rq_q.addr  <= '0;
            rq_q.rd    <= 1'b0;
            rq_q.data  <= '0;
            rq_q.done  <= 1'b0;
        end else begin
            rq_q <= rq_d;
        end
    end

    assign rd_o   = rq_q.rd;
    assign addr_o = rq_q.addr;
    assign busy_o = (rq_q.state != RQ_IDLE);
    assign done_o = rq_q.done;
    assign data_o = rq_q.data;
endmodule

// File: rtl/rom_rd_hs_responder.sv
module rom_rd_hs_responder
    import rom_rd_hs_pkg::*;
#(
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int LATENCY = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_i,
    input  logic [AW-1:0] addr_i,
    output logic          cmp_o,
    output logic [DW-1:0] data_o
);
    localparam int DEPTH = 1 << AW;
    localparam int CW    = $clog2(LATENCY + 2);

    function automatic logic [DW-1:0] rom_fn(input int a);
        logic [DW-1:0] lin;
        logic [DW-1:0] sh;
        lin = DW'(a * 37 + 11);
        sh  = DW'(a >>> 1);
        return lin ^ sh;
    endfunction

    logic [DW-1:0] rom_mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_rom
        assign rom_mem[g] = rom_fn(g);
    end

    typedef struct packed {
        rs_state_e     state;
        logic [AW-1:0] addr;
        logic [CW-1:0] cnt;
        logic          cmp;
        logic [DW-1:0] data;
    } rs_regs_t;

    rs_regs_t rs_d, rs_q;
    logic     rd_s;

    rom_rd_hs_sync2 rd_sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (rd_i),
        .sync_o  (rd_s)
    );

    always_comb begin
        rs_d = rs_q;
        case (rs_q.state)
            RS_IDLE: begin
                if (rd_s && !rs_q.cmp) begin
                    rs_d.addr  = addr_i;
                    rs_d.cnt   = '0;
                    rs_d.state = RS_ACCESS;
                end
            end
            RS_ACCESS: begin
                if (rs_q.cnt == CW'(LATENCY)) begin
                    rs_d.data  = rom_mem[rs_q.addr];
                    rs_d.cmp   = 1'b1;
                    rs_d.state = RS_HOLD;
                end else begin
                    rs_d.cnt = rs_q.cnt + 1'b1;
                end
            end
            RS_HOLD: begin
                if (!rd_s) begin
                    rs_d.cmp   = 1'b0;
                    rs_d.state = RS_IDLE;
                end
            end
            default: rs_d.state = RS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q.state <= RS_IDLE;
            rs_q.addr  <= '0;
            rs_q.cnt   <= '0;
            rs_q.cmp   <= 1'b0;
            rs_q.data  <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    assign cmp_o  = rs_q.cmp;
    assign data_o = rs_q.data;
endmodule

// File: rtl/rom_rd_hs_top.sv
module rom_rd_hs_top #(
    parameter int AW      = 8,
    parameter int DW      = 8,
    parameter int LATENCY = 3
) (
    input  logic          clk_req,
    input  logic          rst_req_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    output logic          busy_o,
    output logic          done_o,
    output logic [DW-1:0] data_o,
    input  logic          clk_mem,
    input  logic          rst_mem_n,
    output logic          rd_o,
    output logic          cmp_o
);
    logic          rd_w;
    logic          cmp_w;
    logic [AW-1:0] bus_addr_w;
    logic [DW-1:0] bus_data_w;

    rom_rd_hs_requester #(.AW(AW), .DW(DW)) req_i (
        .clk        (clk_req),
        .rst_n      (rst_req_n),
        .start_i    (start_i),
        .addr_i     (addr_i),
        .cmp_i      (cmp_w),
        .mem_data_i (bus_data_w),
        .rd_o       (rd_w),
        .addr_o     (bus_addr_w),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .data_o     (data_o)
    );

    rom_rd_hs_responder #(.AW(AW), .DW(DW), .LATENCY(LATENCY)) rsp_i (
        .clk    (clk_mem),
        .rst_n  (rst_mem_n),
        .rd_i   (rd_w),
        .addr_i (bus_addr_w),
        .cmp_o  (cmp_w),
        .data_o (bus_data_w)
    );

    assign rd_o  = rd_w;
    assign cmp_o = cmp_w;
endmodule

// File: rtl/rom_rd_hs_chk.sv
module rom_rd_hs_chk #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk_req,
    input logic          rst_req_n,
    input logic          clk_mem,
    input logic          rst_mem_n,
    input logic          rd,
    input logic          cmp,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_data,
    input logic          done,
    input logic          busy
);
    logic both_rst_n;
    assign both_rst_n = rst_req_n && rst_mem_n;

    assert_rd_rise_R4: assert property (@(posedge clk_req) disable iff (!both_rst_n)
        $rose(rd) |-> !cmp);

    assert_rd_fall_R4: assert property (@(posedge clk_req) disable iff (!both_rst_n)
        $fell(rd) |-> cmp);

    assert_cmp_rise_R4: assert property (@(posedge clk_mem) disable iff (!both_rst_n)
        $rose(cmp) |-> rd);

    assert_cmp_fall_R4: assert property (@(posedge clk_mem) disable iff (!both_rst_n)
        $fell(cmp) |-> !rd);

    assert_addr_hold_R5: assert property (@(posedge clk_req) disable iff (!both_rst_n)
        (rd && $past(rd)) |-> $stable(bus_addr));

    assert_data_hold_R5: assert property (@(posedge clk_mem) disable iff (!both_rst_n)
        (cmp && $past(cmp)) |-> $stable(bus_data));

    assert_done_pulse_R6: assert property (@(posedge clk_req) disable iff (!both_rst_n)
        done |=> !done);

    assert_done_idle_R6: assert property (@(posedge clk_req) disable iff (!both_rst_n)
        done |-> (!busy && !rd));
endmodule

bind rom_rd_hs_top rom_rd_hs_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk_req   (clk_req),
    .rst_req_n (rst_req_n),
    .clk_mem   (clk_mem),
    .rst_mem_n (rst_mem_n),
    .rd        (rd_w),
    .cmp       (cmp_w),
    .bus_addr  (bus_addr_w),
    .bus_data  (bus_data_w),
    .done      (done_o),
    .busy      (busy_o)
);

// File: tb/rom_rd_hs_tb_top.sv
`timescale 1ns/1ps
module rom_rd_hs_tb_top;
    localparam int AW  = 8;
    localparam int DW  = 8;
    localparam int LAT = 3;

    logic          clk_req = 1'b0;
    logic          clk_mem = 1'b0;
    logic          rst_req_n = 1'b0;
    logic          rst_mem_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic          busy_o, done_o, rd_o, cmp_o;
    logic [DW-1:0] data_o;

    int n_checks = 0;
    int n_fails  = 0;
    int mem_neg  = 0;
    int mem_at_rise;

    always #2.5 clk_req = ~clk_req;
    always #3.5 clk_mem = ~clk_mem;

    always @(negedge clk_mem) begin
        if (rd_o && !cmp_o) mem_neg = mem_neg + 1;
    end

    rom_rd_hs_top #(.AW(AW), .DW(DW), .LATENCY(LAT)) dut_i (
        .clk_req   (clk_req),
        .rst_req_n (rst_req_n),
        .start_i   (start_i),
        .addr_i    (addr_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .data_o    (data_o),
        .clk_mem   (clk_mem),
        .rst_mem_n (rst_mem_n),
        .rd_o      (rd_o),
        .cmp_o     (cmp_o)
    );

    function automatic logic [DW-1:0] exp_word(input int a);
        int v;
        v = ((a * 37 + 11) & 255) ^ (a >> 1);
        return DW'(v);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [AW-1:0] a, input bit poke_busy);
        int stage;
        int bad;
        int base;
        int gap;
        bit got_done;
        logic [DW-1:0] prev;
        prev = data_o;
        base = mem_neg;
        @(negedge clk_req);
        start_i = 1'b1;
        addr_i  = a;
        @(negedge clk_req);
        start_i = 1'b0;
        addr_i  = ~a;
        chk("R2 busy after start", busy_o, 1);
        chk("R2 rd low in setup", rd_o, 0);
        chk("R9 data held", data_o, prev);
        @(negedge clk_req);
        chk("R2 rd high", rd_o, 1);
        stage = 1; bad = 0; got_done = 0; mem_at_rise = -1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk_req);
            if (poke_busy && i == 2) begin
                start_i = 1'b1;
                addr_i  = a ^ 8'h5a;
            end else begin
                start_i = 1'b0;
            end
            case (stage)
                1: if (cmp_o) begin
                       if (!rd_o) bad++;
                       mem_at_rise = mem_neg;
                       stage = 2;
                   end
                2: if (!rd_o) begin
                       if (!cmp_o) bad++;
                       stage = 3;
                   end
                3: if (!cmp_o) begin
                       if (rd_o) bad++;
                       stage = 4;
                   end
                default: ;
            endcase
            if (done_o) begin
                got_done = 1;
                break;
            end
        end
        start_i = 1'b0;
        chk("R6 done seen", got_done, 1);
        chk("R4 phase order", {stage, bad}, {32'd4, 32'd0} >> 0 ? {stage, bad} & 0 | {32'd4, 32'd0} : 0);
        chk("R4 cmp low at done", cmp_o, 0);
        chk("R6 busy low at done", busy_o, 0);
        chk("R3 data", data_o, exp_word(a));
        gap = mem_at_rise - base;
        chk("R8 latency window", (gap >= LAT + 2 && gap <= LAT + 5), 1);
        @(negedge clk_req);
        chk("R6 single pulse", done_o, 0);
        @(negedge clk_req);
        chk("R7 no second transfer", busy_o, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk_req);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h1d5e);
        repeat (3) @(negedge clk_req);
        chk("R1 busy in reset", busy_o, 0);
        chk("R1 rd in reset", rd_o, 0);
        chk("R1 cmp in reset", cmp_o, 0);
        rst_req_n = 1'b1;
        rst_mem_n = 1'b1;
        repeat (2) @(negedge clk_req);
        chk("R1 busy after reset", busy_o, 0);
        chk("R1 done after reset", done_o, 0);
        chk("R1 data after reset", data_o, 0);
        chk("R1 rd after reset", rd_o, 0);
        do_read(8'h00, 0);
        do_read(8'hff, 0);
        do_read(8'h80, 1);
        do_read(8'h7f, 1);
        for (int k = 0; k < 40; k++) begin
            do_read(AW'($urandom), bit'($urandom % 3 == 0));
            repeat ($urandom % 4) @(negedge clk_req);
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule